// File: doc/BRIEF.md
# Four-Lane Permutation Unit

This unit rearranges 32-bit elements of two 128-bit operands, a destination operand and a source operand, into one 128-bit result. A 3-bit opcode picks one of several permutations. The permutations are an immediate-driven shuffle, an interleave of either the upper or the lower element pairs, and a swap of 64-bit halves in either direction. A further operation gathers the sign bit of every source element into a 4-bit mask. Lane 0 is bits 31:0, and lane k occupies bits 32k+31:32k.

Every lane select is made from the operand values as presented, so a single input lane may feed several result lanes. The outputs are registered. A request is accepted in the cycle where `in_valid` is high, and its result appears one cycle later with `out_valid` high.

Top module: `lane_perm_unit`

## Requirements
- R1: With opcode 0 (shuffle), result lane 0 is the dest lane indexed by imm[1:0], and result lane 1 is the dest lane indexed by imm[3:2].
- R2: With opcode 0 (shuffle), result lane 2 is the src lane indexed by imm[5:4], and result lane 3 is the src lane indexed by imm[7:6].
- R3: With opcode 1 (upper interleave), the result from lane 3 down to lane 0 is {src lane 3, dest lane 3, src lane 2, dest lane 2}.
- R4: With opcode 2 (lower interleave), the result from lane 3 down to lane 0 is {src lane 1, dest lane 1, src lane 0, dest lane 0}.
- R5: With opcode 3 (upper-to-lower move), result bits 63:0 equal src bits 127:64, and result bits 127:64 equal dest bits 127:64.
- R6: With opcode 4 (lower-to-upper move), result bits 127:64 equal src bits 63:0, and result bits 63:0 equal dest bits 63:0.
- R7: With opcode 5 (sign gather), mask bits 3:0 equal src bits 127, 95, 63 and 31 (bit 3 down to bit 0). Mask bits 31:4 are zero, and the result equals dest.
- R8: For every opcode other than 5, the mask output is zero.
- R9: Opcodes 6 and 7 return dest unchanged as the result.
- R10: The result of an accepted request appears one clock after acceptance, and `out_valid` is then high. In a cycle where `in_valid` is low, `out_valid` goes low in the next cycle and the result and mask keep their values.
- R11: A synchronous reset clears `out_valid`, the result and the mask to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation code |
| in_imm | input | 8 | Shuffle lane selects, four 2-bit fields |
| in_dest | input | 128 | Destination operand |
| in_src | input | 128 | Source operand |
| out_valid | output | 1 | Registered result is new |
| out_result | output | 128 | Permuted operand |
| out_mask | output | 32 | Sign-bit gather, zero-extended |

## Verification
The assertions check each result against the operands of the previous cycle. They therefore assume that the inputs are stable across the accepting clock edge and contain no X, and they assume no request is made during reset. The bench drives every input on the falling edge, from known values only. It holds reset quiet with `in_valid` low and keeps every opcode, including the unused ones, inside its 3-bit field. All 256 immediates are covered with random operands.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;
    localparam int LANE_W  = 32;
    localparam int LANES   = 4;
    localparam int VEC_W   = LANE_W * LANES;
    localparam int HALF_W  = VEC_W / 2;
    localparam int SEL_W   = $clog2(LANES);
    localparam int IMM_W   = SEL_W * LANES;
    localparam int MASK_W  = 32;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [LANES-1:0] vec_t;

    typedef enum logic [2:0] {
        OP_SHUF   = 3'd0,
        OP_MIX_HI = 3'd1,
        OP_MIX_LO = 3'd2,
        OP_HI2LO  = 3'd3,
        OP_LO2HI  = 3'd4,
        OP_SIGNS  = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } perm_op_e;

    function automatic lane_t pick_lane(input vec_t v, input logic [SEL_W-1:0] sel);
        return v[sel];
    endfunction
endpackage

// File: rtl/lane_shuffle.sv
module lane_shuffle
    import lane_perm_pkg::*;
(
    input  vec_t              dest,
    input  vec_t              src,
    input  logic [IMM_W-1:0]  imm,
    output vec_t              res
);
    localparam int LOW_LANES = LANES / 2;
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SEL_W-1:0] sel;
        assign sel = imm[g*SEL_W +: SEL_W];
        if (g < LOW_LANES) begin : g_from_dest
            assign res[g] = pick_lane(dest, sel);
        end else begin : g_from_src
            assign res[g] = pick_lane(src, sel);
        end
    end
endmodule

// File: rtl/lane_interleave.sv
module lane_interleave
    import lane_perm_pkg::*;
(
    input  vec_t dest,
    input  vec_t src,
    input  logic upper,
    output vec_t res
);
    localparam int BASE_HI = LANES / 2;
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int PAIR = g / 2;
        if (g % 2 == 0) begin : g_even
            assign res[g] = upper ? dest[BASE_HI + PAIR] : dest[PAIR];
        end else begin : g_odd
            assign res[g] = upper ? src[BASE_HI + PAIR] : src[PAIR];
        end
    end
endmodule

// File: rtl/half_move.sv
module half_move
    import lane_perm_pkg::*;
(
    input  logic [VEC_W-1:0] dest,
    input  logic [VEC_W-1:0] src,
    input  logic             to_low,
    output logic [VEC_W-1:0] res
);
    always_comb begin
        if (to_low) res = {dest[VEC_W-1:HALF_W], src[VEC_W-1:HALF_W]};
        else        res = {src[HALF_W-1:0], dest[HALF_W-1:0]};
    end
endmodule

// File: rtl/sign_gather.sv
module sign_gather
    import lane_perm_pkg::*;
(
    input  vec_t              src,
    output logic [MASK_W-1:0] mask
);
    logic [LANES-1:0] signs;
    for (genvar g = 0; g < LANES; g++) begin : g_sign
        assign signs[g] = src[g][LANE_W-1];
    end
    assign mask = {{(MASK_W-LANES){1'b0}}, signs};
endmodule

// File: rtl/lane_perm_unit.sv
module lane_perm_unit
    import lane_perm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [2:0]   in_op,
    input  logic [7:0]   in_imm,
    input  logic [127:0] in_dest,
    input  logic [127:0] in_src,
    output logic         out_valid,
    output logic [127:0] out_result,
    output logic [31:0]  out_mask
);
    vec_t dest_v, src_v, shuf_v, mix_v;
    logic [VEC_W-1:0] move_v;
    logic [MASK_W-1:0] sign_m;
    perm_op_e op;
    logic [VEC_W-1:0] next_res;
    logic [MASK_W-1:0] next_mask;

    assign dest_v = vec_t'(in_dest);
    assign src_v  = vec_t'(in_src);
    assign op     = perm_op_e'(in_op);

    lane_shuffle u_shuf (.dest(dest_v), .src(src_v), .imm(in_imm), .res(shuf_v));
    lane_interleave u_mix (.dest(dest_v), .src(src_v), .upper(op == OP_MIX_HI), .res(mix_v));
    half_move u_move (.dest(in_dest), .src(in_src), .to_low(op == OP_HI2LO), .res(move_v));
    sign_gather u_sign (.src(src_v), .mask(sign_m));

    always_comb begin
        next_mask = '0;
        unique case (op)
            OP_SHUF:             next_res = shuf_v;
            OP_MIX_HI, OP_MIX_LO: next_res = mix_v;
            OP_HI2LO, OP_LO2HI:  next_res = move_v;
            OP_SIGNS: begin
                next_res  = in_dest;
                next_mask = sign_m;
            end
            default:             next_res = in_dest;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_mask   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= next_res;
                out_mask   <= next_mask;
            end
        end
    end

    // Upper interleave ordering (R3)
    p_mix_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd1) |=>
        out_result == {$past(in_src[127:96]), $past(in_dest[127:96]),
                       $past(in_src[95:64]),  $past(in_dest[95:64])});
    // Lower interleave ordering (R4)
    p_mix_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd2) |=>
        out_result == {$past(in_src[63:32]), $past(in_dest[63:32]),
                       $past(in_src[31:0]),  $past(in_dest[31:0])});
    // Upper-to-lower move (R5)
    p_hi2lo_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd3) |=>
        out_result == {$past(in_dest[127:64]), $past(in_src[127:64])});
    // Lower-to-upper move (R6)
    p_lo2hi_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd4) |=>
        out_result == {$past(in_src[63:0]), $past(in_dest[63:0])});
    // Sign gather bits (R7)
    p_signs_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd5) |=>
        out_mask == {28'd0, $past(in_src[127]), $past(in_src[95]),
                     $past(in_src[63]), $past(in_src[31])});
    // Mask silent outside sign gather (R8)
    p_mask_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != 3'd5) |=> out_mask == 32'd0);
    // Reserved codes pass dest (R9)
    p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2:1] == 2'b11) |=> out_result == $past(in_dest));
    // Valid latency and hold (R10)
    p_valid_lat_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_mask)));
endmodule

// File: tb/lane_perm_unit_test.sv
module lane_perm_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   in_op;
    logic [7:0]   in_imm;
    logic [127:0] in_dest, in_src;
    logic         out_valid;
    logic [127:0] out_result;
    logic [31:0]  out_mask;

    int checks = 0;
    int errors = 0;
    logic [127:0] last_res;
    logic [31:0]  last_mask;

    always #5 clk = ~clk;

    lane_perm_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_imm(in_imm),
        .in_dest(in_dest), .in_src(in_src), .out_valid(out_valid),
        .out_result(out_result), .out_mask(out_mask)
    );

    function automatic logic [31:0] ln(input logic [127:0] v, input int k);
        return v[32*k +: 32];
    endfunction

    function automatic logic [127:0] model_res(input int op, input logic [7:0] imm,
                                               input logic [127:0] d, input logic [127:0] s);
        logic [127:0] r;
        r = d;
        case (op)
            0: r = {ln(s, int'(imm[7:6])), ln(s, int'(imm[5:4])),
                    ln(d, int'(imm[3:2])), ln(d, int'(imm[1:0]))};
            1: r = {ln(s, 3), ln(d, 3), ln(s, 2), ln(d, 2)};
            2: r = {ln(s, 1), ln(d, 1), ln(s, 0), ln(d, 0)};
            3: r = {d[127:64], s[127:64]};
            4: r = {s[63:0], d[63:0]};
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] model_mask(input int op, input logic [127:0] s);
        logic [31:0] m;
        m = 32'd0;
        if (op == 5) for (int k = 0; k < 4; k++) m[k] = s[32*k + 31];
        return m;
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0: return "R1/R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk_res(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s result got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Drive one request at a falling edge and compare at the next falling edge
    task automatic issue(input int op, input logic [7:0] imm,
                         input logic [127:0] d, input logic [127:0] s);
        logic [127:0] er;
        logic [31:0]  em;
        in_valid = 1'b1; in_op = op[2:0]; in_imm = imm; in_dest = d; in_src = s;
        er = model_res(op, imm, d, s);
        em = model_mask(op, s);
        @(negedge clk);
        chk_word("R10 valid", {31'd0, out_valid}, 32'd1);
        chk_res(tag_of(op), out_result, er);
        if (op == 5) chk_word("R7 mask", out_mask, em);
        else         chk_word("R8 mask", out_mask, 32'd0);
        last_res = er;
        last_mask = em;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = 3'd0; in_imm = 8'd0;
        in_dest = '0; in_src = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk_word("R11 valid", {31'd0, out_valid}, 32'd0);
        chk_res("R11", out_result, 128'd0);
        chk_word("R11 mask", out_mask, 32'd0);

        // R1 R2: every immediate with random operands
        for (int i = 0; i < 256; i++) issue(0, i[7:0], rnd128(), rnd128());
        // Repeated lane fan-out: one dest lane feeds both low lanes (R1)
        issue(0, 8'b11_00_10_10, 128'h4444_4444_3333_3333_2222_2222_1111_1111,
              128'h8888_8888_7777_7777_6666_6666_5555_5555);

        // R3..R9 with random and edge patterns
        for (int op = 1; op < 8; op++) begin
            issue(op, 8'h00, 128'd0, {128{1'b1}});
            issue(op, 8'hFF, {128{1'b1}}, 128'd0);
            for (int i = 0; i < 20; i++) issue(op, $urandom, rnd128(), rnd128());
        end
        // R7 single sign bits in each lane
        for (int k = 0; k < 4; k++) issue(5, 8'h00, rnd128(), 128'd1 << (32*k + 31));

        // R10: idle cycle holds outputs, valid drops
        issue(5, 8'h00, rnd128(), 128'h8000_0000_0000_0000_8000_0000_0000_0000);
        in_valid = 1'b0; in_op = 3'd0; in_dest = rnd128(); in_src = rnd128();
        @(negedge clk);
        chk_word("R10 idle valid", {31'd0, out_valid}, 32'd0);
        chk_res("R10 hold", out_result, last_res);
        chk_word("R10 hold mask", out_mask, last_mask);
        @(negedge clk);
        chk_res("R10 hold2", out_result, last_res);

        // R11: reset mid-stream clears outputs
        issue(2, 8'h00, rnd128(), rnd128());
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk_res("R11 again", out_result, 128'd0);
        chk_word("R11 again valid", {31'd0, out_valid}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule